// File: doc/BRIEF.md
# Fractional-Divider Serial Transmitter

This block turns parallel words from a host write port into asynchronous serial frames on a single transmit line. Each frame has a low start bit, a data word of eight or nine bits sent least significant bit first, and a high stop interval. The stop interval can be a half, one, one and a half or two bit times. The bit time comes from a 16-bit fixed-point divisor of the system clock. Its upper 12 bits are whole clocks and its lower 4 bits are sixteenths of a clock. Timing is built in half-bit steps, so fractional divisors and half-bit stop lengths share one mechanism.

The host writes into a one-word holding buffer. The buffer hands its word to the shift stage when a frame starts, so the host can queue the next word while the current one is on the line. An active-low clear-to-send input is sampled only at frame boundaries: a frame in flight always finishes, and no new frame starts while the input is high. The host can also ask for one idle preamble, which holds the line high for the length of a frame before any queued data goes out.

The controller is a five-state machine:
- IDLE: the line is high. The machine goes to PREAMBLE when a preamble is pending and clear-to-send is low. Otherwise it goes to START when a word is buffered and clear-to-send is low.
- START: two half-bit steps, then DATA.
- DATA: two half-bit steps per data bit, then STOP.
- STOP: one to four half-bit steps, set by the stop code.
- PREAMBLE: as many half-bit steps as a full frame, with the line high.

At the last step of STOP or PREAMBLE the machine makes the same choice as in IDLE: PREAMBLE, START or IDLE.

Top module: `uart_frac_tx`

## Requirements
- R1: Out of reset, txd is high, tx_empty is 1 and tx_done is 1.
- R2: A frame drives txd low for the start bit, then sends the data bits least significant bit first, then drives txd high for the stop interval. Between frames txd stays high.
- R3: With cfg_nine = 1 the word has 9 bits (wr_data[8] is sent last). With cfg_nine = 0 it has 8 bits and wr_data[8] is not sent.
- R4: Let D be cfg_div read as an unsigned number in sixteenths of a clock, with D at least 32. Half-bit boundary k of a frame appears on txd ceil(k*D/32) cycles after the first cycle of its start bit.
- R5: The cfg_stop code sets the stop interval: 2'b00 gives 1 bit, 2'b01 gives 0.5 bit, 2'b10 gives 2 bits and 2'b11 gives 1.5 bits.
- R6: When the block is idle and clear-to-send is low, a write accepted at one clock edge puts the start bit on txd from the second edge after it.
- R7: A write is accepted only while tx_empty is 1, and tx_empty then falls. tx_empty rises in the same cycle that the word's start bit appears. A write while tx_empty is 0 is ignored.
- R8: A word buffered before the current frame ends has its start bit on txd in the first cycle after the last stop half-bit.
- R9: tx_done falls on an accepted write. It rises when the last stop half-bit ends with no word buffered. While tx_done is 1, txd is high.
- R10: A new frame or preamble starts only when cts_n is low. Raising cts_n during a frame does not change that frame.
- R11: A one-cycle idle_req pulse makes one preamble pending. The preamble holds txd high for as many half-bits as a data frame with the current settings. It goes ahead of a word buffered at the same time. When requested from idle, it begins on the same schedule as R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | 16 | Bit-time divisor, 12 integer bits and 4 fraction bits; hold stable while busy |
| cfg_nine | input | 1 | 1 selects 9-bit words, 0 selects 8-bit words |
| cfg_stop | input | 2 | Stop-interval code |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 9 | Word to send |
| idle_req | input | 1 | Pulse to request one idle preamble |
| cts_n | input | 1 | Active-low clear-to-send |
| txd | output | 1 | Serial transmit line |
| tx_empty | output | 1 | Holding buffer can take a word |
| tx_done | output | 1 | Line idle with nothing buffered |

## Verification
An accepted write shows on txd two cycles later. Each half-bit boundary of a frame lands exactly ceil(k*D/32) cycles after the start bit begins. tx_empty rises in the start bit's first cycle, and tx_done rises in the first cycle after the final stop half-bit. The bench drives inputs and samples outputs on falling clock edges. It counts those edges from the stimulus, so it compares every cycle of a frame against the waveform predicted by this formula, not only the bit centres. The preamble's length, and what happens on a back-to-back hand-over or a pause from clear-to-send, are each checked at the exact falling edge where the formula says the line must change.

// File: rtl/uft_pkg.sv
package uft_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_PRE
    } uft_state_e;

    // stop-interval code to a number of half-bit steps
    function automatic logic [2:0] stop_halves(input logic [1:0] code);
        logic [2:0] h;
        case (code)
            2'b00:   h = 3'd2;
            2'b01:   h = 3'd1;
            2'b10:   h = 3'd4;
            default: h = 3'd3;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/uft_halfbit_gen.sv
module uft_halfbit_gen #(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int ACC_W = DIV_W + 1;
    localparam int STEP  = 1 << (FRAC_W + 1);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] div_ext;

    assign div_ext = {1'b0, div};
    assign sum     = acc_q + ACC_W'(STEP);
    assign tick    = run && (sum >= div_ext);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            acc_q <= '0;
        else if (!run || load) acc_q <= '0;
        else if (tick)         acc_q <= sum - div_ext;
        else                   acc_q <= sum;
    end
endmodule

// File: rtl/uft_hold_buf.sv
module uft_hold_buf #(
    parameter int MAX_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [MAX_W-1:0] wr_data,
    input  logic             take,
    output logic             valid,
    output logic             accept,
    output logic [MAX_W-1:0] data
);
    logic             valid_q;
    logic [MAX_W-1:0] data_q;

    assign accept = wr_en && !valid_q;
    assign valid  = valid_q;
    assign data   = data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else if (accept) begin
            valid_q <= 1'b1;
            data_q  <= wr_data;
        end else if (take) begin
            valid_q <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_frac_tx.sv
module uart_frac_tx
    import uft_pkg::*;
#(
    parameter int INT_W  = 12,
    parameter int FRAC_W = 4,
    parameter int MAX_W  = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [INT_W+FRAC_W-1:0] cfg_div,
    input  logic                    cfg_nine,
    input  logic [1:0]              cfg_stop,
    input  logic                    wr_en,
    input  logic [MAX_W-1:0]        wr_data,
    input  logic                    idle_req,
    input  logic                    cts_n,
    output logic                    txd,
    output logic                    tx_empty,
    output logic                    tx_done
);
    localparam int DIV_W      = INT_W + FRAC_W;
    localparam int MAX_HALVES = 2 * (MAX_W + 1) + 4;
    localparam int CNT_W      = $clog2(MAX_HALVES + 1);

    uft_state_e       state_q, state_d, pick;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] nbits_h, stop_h, frame_h;
    logic [MAX_W-1:0] shift_q, hold_data;
    logic             hold_valid, accept, take;
    logic             half_tick, run, frame_go, frame_end;
    logic             pre_pend_q, done_q;

    assign run     = (state_q != ST_IDLE);
    assign nbits_h = cfg_nine ? CNT_W'(2 * MAX_W) : CNT_W'(2 * MAX_W - 2);
    assign stop_h  = CNT_W'(stop_halves(cfg_stop));
    assign frame_h = CNT_W'(2) + nbits_h + stop_h;

    uft_halfbit_gen #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .load (frame_go),
        .div  (cfg_div),
        .tick (half_tick)
    );

    uft_hold_buf #(.MAX_W(MAX_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .take   (take),
        .valid  (hold_valid),
        .accept (accept),
        .data   (hold_data)
    );

    // next-state logic
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        frame_go  = 1'b0;
        frame_end = 1'b0;
        if (!cts_n && pre_pend_q)      pick = ST_PRE;
        else if (!cts_n && hold_valid) pick = ST_START;
        else                           pick = ST_IDLE;

        unique case (state_q)
            ST_IDLE: begin
                if (pick != ST_IDLE) begin
                    state_d  = pick;
                    cnt_d    = '0;
                    frame_go = 1'b1;
                end
            end
            ST_START: begin
                if (half_tick) begin
                    if (cnt_q == CNT_W'(1)) begin
                        state_d = ST_DATA;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (half_tick) begin
                    if (cnt_q == nbits_h - 1'b1) begin
                        state_d = ST_STOP;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_STOP: begin
                if (half_tick) begin
                    if (cnt_q == stop_h - 1'b1) frame_end = 1'b1;
                    else                        cnt_d = cnt_q + 1'b1;
                end
            end
            ST_PRE: begin
                if (half_tick) begin
                    if (cnt_q == frame_h - 1'b1) frame_end = 1'b1;
                    else                         cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase

        if (frame_end) begin
            state_d  = pick;
            cnt_d    = '0;
            frame_go = (pick != ST_IDLE);
        end
        take = frame_go && (pick == ST_START);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q    <= '0;
            pre_pend_q <= 1'b0;
            done_q     <= 1'b1;
        end else begin
            if (take)
                shift_q <= hold_data;
            else if (state_q == ST_DATA && half_tick && cnt_q[0])
                shift_q <= shift_q >> 1;

            if (idle_req)                            pre_pend_q <= 1'b1;
            else if (frame_go && pick == ST_PRE)     pre_pend_q <= 1'b0;

            if (accept)                                      done_q <= 1'b0;
            else if (frame_end && !frame_go && !hold_valid)  done_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = shift_q[0];
            default:  txd = 1'b1;
        endcase
        tx_empty = !hold_valid;
        tx_done  = done_q;
    end
endmodule

// File: rtl/uft_tx_checker.sv
module uft_tx_checker
    import uft_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 4,
    parameter int MAX_W  = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             cts_n,
    input logic             txd,
    input logic             tx_empty,
    input logic             tx_done,
    input logic [MAX_W-1:0] hold_data,
    input logic             tick,
    input logic             load,
    input logic             run,
    input logic [DIV_W-1:0] div,
    input uft_state_e       state
);
    localparam int STEP = 1 << (FRAC_W + 1);

    logic [DIV_W-1:0] gap_q;
    int unsigned      scaled, div_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     gap_q <= DIV_W'(1);
        else if (!run || load || tick)  gap_q <= DIV_W'(1);
        else                            gap_q <= gap_q + 1'b1;
    end

    always_comb begin
        scaled = int'(gap_q) * STEP;
        div_i  = int'(div);
    end

    // R4: spacing of half-bit steps stays within one clock of D/32
    p_step_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick) |-> ((scaled + STEP > div_i) && (scaled < div_i + STEP)));

    p_full_write_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !tx_empty) |=> $stable(hold_data));

    p_empty_falls_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_empty) |-> $past(wr_en));

    p_done_line_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> txd);

    p_done_nothing_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> tx_empty);

    p_start_needs_cts_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && $past(state) != ST_START) |-> !$past(cts_n));
endmodule

bind uart_frac_tx uft_tx_checker #(
    .DIV_W (INT_W + FRAC_W),
    .FRAC_W(FRAC_W),
    .MAX_W (MAX_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .cts_n    (cts_n),
    .txd      (txd),
    .tx_empty (tx_empty),
    .tx_done  (tx_done),
    .hold_data(hold_data),
    .tick     (half_tick),
    .load     (frame_go),
    .run      (run),
    .div      (cfg_div),
    .state    (state_q)
);

// File: tb/test_uart_frac_tx.sv
module test_uart_frac_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_div = 16'd160;
    logic        cfg_nine = 1'b0;
    logic [1:0]  cfg_stop = 2'b00;
    logic        wr_en = 1'b0;
    logic [8:0]  wr_data = '0;
    logic        idle_req = 1'b0;
    logic        cts_n = 1'b0;
    logic        txd, tx_empty, tx_done;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    uart_frac_tx i_uart_frac_tx (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_nine(cfg_nine),
        .cfg_stop(cfg_stop), .wr_en(wr_en), .wr_data(wr_data),
        .idle_req(idle_req), .cts_n(cts_n), .txd(txd),
        .tx_empty(tx_empty), .tx_done(tx_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int halves_of_stop(input logic [1:0] code);
        case (code)
            2'b00:   return 2;
            2'b01:   return 1;
            2'b10:   return 4;
            default: return 3;
        endcase
    endfunction

    function automatic int frame_cycles(input bit nine, input logic [1:0] code, input int d);
        int h;
        h = 2 * (1 + (nine ? 9 : 8)) + halves_of_stop(code);
        return (h * d + 31) / 32;
    endfunction

    task automatic set_cfg(input int d, input bit nine, input logic [1:0] code);
        @(negedge clk);
        cfg_div  = 16'(d);
        cfg_nine = nine;
        cfg_stop = code;
    endtask

    // starts and ends on a falling edge; two edges elapse
    task automatic do_write(input logic [8:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // called on a falling edge; leaves at the falling edge of the first cycle after the frame
    task automatic check_frame(input logic [8:0] d, input string req);
        int tmo = 0;
        int n, m, bad, first_c;
        logic act_v, exp_v;
        while (txd !== 1'b0 && tmo < 20000) begin
            @(negedge clk);
            tmo++;
        end
        if (tmo >= 20000) begin
            chk(1'b0, req, "start bit never seen", 1, 0);
            return;
        end
        n = cfg_nine ? 9 : 8;
        m = frame_cycles(cfg_nine, cfg_stop, int'(cfg_div));
        bad = 0; first_c = 0; act_v = 1'b0; exp_v = 1'b0;
        for (int c = 0; c < m; c++) begin
            int h;
            logic e;
            h = (32 * c) / int'(cfg_div);
            if (h < 2)              e = 1'b0;
            else if (h < 2 + 2 * n) e = d[(h - 2) / 2];
            else                    e = 1'b1;
            if (txd !== e) begin
                if (bad == 0) begin
                    act_v = txd; exp_v = e; first_c = c;
                end
                bad++;
            end
            @(negedge clk);
        end
        chk(bad == 0, req, $sformatf("txd at frame cycle %0d", first_c), int'(act_v), int'(exp_v));
    endtask

    task automatic stay_high(input int cycles, input string req, input bit exp_done,
                             input bit exp_empty);
        int bad = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (txd !== 1'b1 || tx_done !== exp_done || tx_empty !== exp_empty) bad++;
        end
        chk(bad == 0, req, "line held high / flags steady (bad cycles)", bad, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(txd === 1'b1, "R1", "txd after reset", int'(txd), 1);
        chk(tx_empty === 1'b1, "R1", "tx_empty after reset", int'(tx_empty), 1);
        chk(tx_done === 1'b1, "R1", "tx_done after reset", int'(tx_done), 1);
    endtask

    task automatic t_basic();
        set_cfg(160, 1'b0, 2'b00);
        do_write(9'h0A5);
        chk(txd === 1'b1, "R6", "txd one cycle after accept", int'(txd), 1);
        chk(tx_empty === 1'b0, "R7", "tx_empty after accept", int'(tx_empty), 0);
        chk(tx_done === 1'b0, "R9", "tx_done after accept", int'(tx_done), 0);
        @(negedge clk);
        chk(txd === 1'b0, "R6", "start bit two edges after accept", int'(txd), 0);
        chk(tx_empty === 1'b1, "R7", "tx_empty with start bit", int'(tx_empty), 1);
        check_frame(9'h0A5, "R2 R4");
        chk(tx_done === 1'b1, "R9", "tx_done after last stop half", int'(tx_done), 1);
    endtask

    task automatic t_nine_frac();
        set_cfg(149, 1'b1, 2'b10);
        do_write(9'h1A5);
        check_frame(9'h1A5, "R3 R4 R5");
        chk(tx_done === 1'b1, "R5", "done after two stop bits", int'(tx_done), 1);
        set_cfg(149, 1'b0, 2'b00);
        do_write(9'h15A);
        check_frame(9'h05A, "R3");
        chk(txd === 1'b1, "R3", "bit 8 not sent in 8-bit mode", int'(txd), 1);
    endtask

    task automatic t_half_stops();
        set_cfg(37, 1'b0, 2'b01);
        do_write(9'h03C);
        check_frame(9'h03C, "R5");
        chk(tx_done === 1'b1, "R5", "done after half stop", int'(tx_done), 1);
        set_cfg(37, 1'b1, 2'b11);
        do_write(9'h0C3);
        check_frame(9'h0C3, "R5");
        chk(tx_done === 1'b1, "R5", "done after 1.5 stop", int'(tx_done), 1);
    endtask

    task automatic t_back_to_back();
        set_cfg(160, 1'b0, 2'b00);
        fork
            begin
                do_write(9'h033);
                check_frame(9'h033, "R8");
            end
            begin
                repeat (4) @(negedge clk);
                do_write(9'h0CC);
            end
        join
        chk(txd === 1'b0, "R8", "next start bit right after stop", int'(txd), 0);
        chk(tx_empty === 1'b1, "R7", "empty at second start", int'(tx_empty), 1);
        check_frame(9'h0CC, "R8");
    endtask

    task automatic t_ignore_full();
        set_cfg(149, 1'b0, 2'b00);
        fork
            begin
                do_write(9'h011);
                check_frame(9'h011, "R7");
            end
            begin
                repeat (4) @(negedge clk);
                do_write(9'h022);
                do_write(9'h0EE);
            end
        join
        check_frame(9'h022, "R7");
        chk(tx_done === 1'b1, "R7", "write to full buffer dropped (done)", int'(tx_done), 1);
        stay_high(300, "R7", 1'b1, 1'b1);
    endtask

    task automatic t_cts();
        set_cfg(160, 1'b0, 2'b00);
        cts_n = 1'b1;
        do_write(9'h0F0);
        stay_high(200, "R10", 1'b0, 1'b0);
        cts_n = 1'b0;
        @(negedge clk);
        chk(txd === 1'b0, "R10", "start after cts_n low", int'(txd), 0);
        check_frame(9'h0F0, "R10");
        fork
            begin
                do_write(9'h05F);
                check_frame(9'h05F, "R10");
            end
            begin
                repeat (4) @(negedge clk);
                do_write(9'h0A0);
                repeat (6) @(negedge clk);
                cts_n = 1'b1;
            end
        join
        stay_high(200, "R10", 1'b0, 1'b0);
        cts_n = 1'b0;
        check_frame(9'h0A0, "R10");
    endtask

    task automatic t_preamble();
        int m, bad;
        set_cfg(160, 1'b0, 2'b00);
        m = frame_cycles(1'b0, 2'b00, 160);
        @(negedge clk);
        idle_req = 1'b1;
        wr_en    = 1'b1;
        wr_data  = 9'h096;
        bad = 0;
        for (int k = 1; k <= m + 1; k++) begin
            @(negedge clk);
            idle_req = 1'b0;
            wr_en    = 1'b0;
            if (txd !== 1'b1 || tx_empty !== 1'b0) bad++;
        end
        chk(bad == 0, "R11", "preamble high with word held (bad cycles)", bad, 0);
        @(negedge clk);
        chk(txd === 1'b0, "R11", "start bit right after preamble", int'(txd), 0);
        check_frame(9'h096, "R11");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_nine_frac();
        t_half_stops();
        t_back_to_back();
        t_ignore_full();
        t_cts();
        t_preamble();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule